// File: doc/BRIEF.md
# Three-Port Latchable Word Router

A routing switch for 9-bit words between three bidirectional ports, here called A, B and C. Each port is split into an input word, an output word and an output-enable flag, so no tri-state pins are used. Every port has its own holding register. The register captures that port's input on a clock edge while the port's load enable is high. A shared two-bit source select picks one held word, and every port whose drive enable is high presents that word. This gives any-to-any routing, and a port can also read back its own held word for self-check.

Bit 8 of each word is meant to carry parity. A parity-flip control inverts bit 8 only when the source is C and the driven port is A or B. Port C reading back its own word is never altered, and bits 0 to 7 always pass through unchanged.

Top module: `word_router3`

## Requirements
- R1: While the active-low asynchronous reset rst_ni is low, all three holding registers clear to zero.
- R2: On a rising clock edge where a port's load enable is high, that port's holding register captures the port's input word. With the load enable low, the register keeps its value.
- R3: The load enables are independent. Loading one port never changes the other two registers.
- R4: The source select encoding is 2'b00 for register A, 2'b01 for register B, 2'b10 for register C and 2'b11 for an all-zero word. The selected word appears combinationally on every enabled port.
- R5: A port with its drive enable high sets its oe flag to 1. A port with its drive enable low sets its oe flag to 0 and drives an all-zero word.
- R6: A port may read back its own held word when the select points at its own register.
- R7: When parity_flip is 1 and the select is 2'b10, bit 8 of the words on ports A and B is inverted, and bits 0 to 7 are unchanged.
- R8: Port C is never parity-inverted, and parity_flip has no effect for any source other than C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 9 | Port A incoming word |
| b_i | input | 9 | Port B incoming word |
| c_i | input | 9 | Port C incoming word |
| ld_a_i | input | 1 | Load enable for register A |
| ld_b_i | input | 1 | Load enable for register B |
| ld_c_i | input | 1 | Load enable for register C |
| src_sel_i | input | 2 | Source select (00 A, 01 B, 10 C, 11 zero) |
| drv_a_i | input | 1 | Drive enable for port A |
| drv_b_i | input | 1 | Drive enable for port B |
| drv_c_i | input | 1 | Drive enable for port C |
| parity_flip_i | input | 1 | Invert bit 8 on the C-to-A and C-to-B paths |
| a_o | output | 9 | Port A outgoing word |
| b_o | output | 9 | Port B outgoing word |
| c_o | output | 9 | Port C outgoing word |
| a_oe_o | output | 1 | Port A output enable |
| b_oe_o | output | 1 | Port B output enable |
| c_oe_o | output | 1 | Port C output enable |

## Verification
A load takes effect at the next rising edge, so a written word can be seen on the ports from that edge on. Select, drive-enable and parity-flip changes reach the outputs in the same cycle, with no register in the path. The bench drives inputs on the falling edge and samples outputs just before the next rising edge. It compares them against a bench-side model of the three registers, which it updates only at the rising edge when a load was requested.

// File: rtl/word_router3_pkg.sv
package word_router3_pkg;
  localparam int unsigned WORD_W  = 9;
  localparam int unsigned NPORTS  = 3;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned PAR_BIT = WORD_W - 1;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [SEL_W-1:0] {
    SRC_A    = 2'b00,
    SRC_B    = 2'b01,
    SRC_C    = 2'b10,
    SRC_ZERO = 2'b11
  } src_e;

  localparam int unsigned PORT_A = 0;
  localparam int unsigned PORT_B = 1;
  localparam int unsigned PORT_C = 2;
endpackage

// File: rtl/word_hold_reg.sv
module word_hold_reg
  import word_router3_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (q_o == $past(d_i)));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(q_o));
endmodule

// File: rtl/word_src_mux.sv
module word_src_mux
  import word_router3_pkg::*;
(
  input  src_e  sel_i,
  input  word_t reg_a_i,
  input  word_t reg_b_i,
  input  word_t reg_c_i,
  output word_t word_o,
  output logic  from_c_o
);
  always_comb begin
    unique case (sel_i)
      SRC_A:   word_o = reg_a_i;
      SRC_B:   word_o = reg_b_i;
      SRC_C:   word_o = reg_c_i;
      default: word_o = '0;
    endcase
  end
  assign from_c_o = (sel_i == SRC_C);

  always_comb begin
    if (sel_i == SRC_ZERO) a_zero_r4: assert (word_o == '0);
  end
endmodule

// File: rtl/port_drive.sv
module port_drive
  import word_router3_pkg::*;
#(
  parameter bit PAR_INV_EN = 1'b1
) (
  input  word_t word_i,
  input  logic  from_c_i,
  input  logic  par_flip_i,
  input  logic  drv_i,
  output word_t word_o,
  output logic  oe_o
);
  word_t adj;

  generate
    if (PAR_INV_EN) begin : g_inv
      always_comb begin
        adj = word_i;
        adj[PAR_BIT] = word_i[PAR_BIT] ^ (from_c_i & par_flip_i);
      end
    end else begin : g_pass
      assign adj = word_i;
    end
  endgenerate

  assign oe_o   = drv_i;
  assign word_o = drv_i ? adj : '0;

  always_comb begin
    if (!drv_i) a_off_zero_r5: assert (word_o == '0);
    if (drv_i)  a_low_bits_r7: assert (word_o[PAR_BIT-1:0] == word_i[PAR_BIT-1:0]);
    if (drv_i && !(from_c_i && par_flip_i))
      a_no_flip_r8: assert (word_o == word_i);
  end
endmodule

// File: rtl/word_router3.sv
module word_router3
  import word_router3_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [8:0] a_i,
  input  logic [8:0] b_i,
  input  logic [8:0] c_i,
  input  logic       ld_a_i,
  input  logic       ld_b_i,
  input  logic       ld_c_i,
  input  logic [1:0] src_sel_i,
  input  logic       drv_a_i,
  input  logic       drv_b_i,
  input  logic       drv_c_i,
  input  logic       parity_flip_i,
  output logic [8:0] a_o,
  output logic [8:0] b_o,
  output logic [8:0] c_o,
  output logic       a_oe_o,
  output logic       b_oe_o,
  output logic       c_oe_o
);
  word_t in_w  [NPORTS];
  word_t reg_w [NPORTS];
  word_t out_w [NPORTS];
  logic  ld_w  [NPORTS];
  logic  drv_w [NPORTS];
  logic  oe_w  [NPORTS];
  word_t sel_word;
  logic  from_c;

  assign in_w[PORT_A] = a_i;    assign in_w[PORT_B] = b_i;    assign in_w[PORT_C] = c_i;
  assign ld_w[PORT_A] = ld_a_i; assign ld_w[PORT_B] = ld_b_i; assign ld_w[PORT_C] = ld_c_i;
  assign drv_w[PORT_A] = drv_a_i; assign drv_w[PORT_B] = drv_b_i; assign drv_w[PORT_C] = drv_c_i;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    word_hold_reg #(.W(WORD_W)) u_reg (
      .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld_w[p]), .d_i(in_w[p]), .q_o(reg_w[p])
    );
    port_drive #(.PAR_INV_EN(p != PORT_C)) u_drv (
      .word_i(sel_word), .from_c_i(from_c), .par_flip_i(parity_flip_i),
      .drv_i(drv_w[p]), .word_o(out_w[p]), .oe_o(oe_w[p])
    );
  end

  word_src_mux u_mux (
    .sel_i(src_e'(src_sel_i)), .reg_a_i(reg_w[PORT_A]), .reg_b_i(reg_w[PORT_B]),
    .reg_c_i(reg_w[PORT_C]), .word_o(sel_word), .from_c_o(from_c)
  );

  assign a_o = out_w[PORT_A]; assign b_o = out_w[PORT_B]; assign c_o = out_w[PORT_C];
  assign a_oe_o = oe_w[PORT_A]; assign b_oe_o = oe_w[PORT_B]; assign c_oe_o = oe_w[PORT_C];

  p_iso_a_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_a_i |=> $stable(reg_w[PORT_A]));
  p_c_never_inv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_c_i && src_sel_i == 2'b10) |-> (c_o == reg_w[PORT_C]));
  p_flip_a_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_a_i && parity_flip_i && src_sel_i == 2'b10) |->
      (a_o == (reg_w[PORT_C] ^ 9'h100)));
  p_oe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_oe_o == drv_a_i) && (b_oe_o == drv_b_i) && (c_oe_o == drv_c_i));
endmodule

// File: tb/word_router3_tb.sv
module word_router3_tb;
  localparam int CLK_T = 10;

  logic clk = 0, rst_n = 0;
  logic [8:0] a_in = 0, b_in = 0, c_in = 0;
  logic ld_a = 0, ld_b = 0, ld_c = 0;
  logic [1:0] sel = 0;
  logic drv_a = 0, drv_b = 0, drv_c = 0, pflip = 0;
  logic [8:0] a_out, b_out, c_out;
  logic a_oe, b_oe, c_oe;

  int checks = 0, errors = 0;
  logic [8:0] m_reg [3];

  always #(CLK_T/2) clk = ~clk;

  word_router3 u_dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_in), .b_i(b_in), .c_i(c_in),
    .ld_a_i(ld_a), .ld_b_i(ld_b), .ld_c_i(ld_c), .src_sel_i(sel),
    .drv_a_i(drv_a), .drv_b_i(drv_b), .drv_c_i(drv_c), .parity_flip_i(pflip),
    .a_o(a_out), .b_o(b_out), .c_o(c_out), .a_oe_o(a_oe), .b_oe_o(b_oe), .c_oe_o(c_oe)
  );

  function automatic logic [8:0] exp_word(int port, logic [1:0] s, logic f, logic drv);
    logic [8:0] w;
    if (!drv) return 9'h0;
    case (s)
      2'b00: w = m_reg[0];
      2'b01: w = m_reg[1];
      2'b10: w = m_reg[2];
      default: w = 9'h0;
    endcase
    if (s == 2'b10 && f && port != 2) w[8] = ~w[8];
    return w;
  endfunction

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(string req);
    chk(req, a_out, exp_word(0, sel, pflip, drv_a));
    chk(req, b_out, exp_word(1, sel, pflip, drv_b));
    chk(req, c_out, exp_word(2, sel, pflip, drv_c));
    chk({req, "_oe"}, {6'b0, a_oe, b_oe, c_oe}, {6'b0, drv_a, drv_b, drv_c});
  endtask

  // drive on negedge, load takes effect at the next posedge, sample before the following posedge
  task automatic cycle(logic la, logic lb, logic lc, logic [8:0] da, logic [8:0] db, logic [8:0] dc);
    @(negedge clk);
    ld_a = la; ld_b = lb; ld_c = lc; a_in = da; b_in = db; c_in = dc;
    @(posedge clk);
    if (la) m_reg[0] = da;
    if (lb) m_reg[1] = db;
    if (lc) m_reg[2] = dc;
    @(negedge clk);
    ld_a = 0; ld_b = 0; ld_c = 0;
  endtask

  task automatic route(logic [1:0] s, logic f, logic da, logic db, logic dc, string req);
    sel = s; pflip = f; drv_a = da; drv_b = db; drv_c = dc;
    #1 check_all(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) m_reg[i] = 0;
    a_in = 9'h1FF; b_in = 9'h1FF; c_in = 9'h1FF; ld_a = 1; ld_b = 1; ld_c = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    ld_a = 0; ld_b = 0; ld_c = 0;
    // R1: registers still zero after clocks with loads held during reset
    route(2'b00, 0, 1, 1, 1, "R1"); route(2'b01, 0, 1, 1, 1, "R1"); route(2'b10, 0, 1, 1, 1, "R1");
    rst_n = 1;

    // R2 load, R3 independence
    cycle(1, 0, 0, 9'h0A5, 9'h111, 9'h122);
    route(2'b00, 0, 1, 1, 1, "R2"); route(2'b01, 0, 1, 1, 1, "R3"); route(2'b10, 0, 1, 1, 1, "R3");
    cycle(0, 1, 0, 9'h000, 9'h15A, 9'h000);
    cycle(0, 0, 1, 9'h000, 9'h000, 9'h1C3);
    route(2'b00, 0, 1, 1, 1, "R3"); route(2'b01, 0, 1, 1, 1, "R2"); route(2'b10, 0, 1, 1, 1, "R2");
    // R2 hold with loads low and inputs changing
    cycle(0, 0, 0, 9'h0FF, 9'h0EE, 9'h0DD);
    route(2'b10, 0, 1, 1, 1, "R2");
    // R4 zero code
    route(2'b11, 1, 1, 1, 1, "R4");
    // R5 disabled ports
    route(2'b01, 0, 0, 1, 0, "R5"); route(2'b00, 0, 0, 0, 0, "R5");
    // R6 self readback
    route(2'b00, 0, 1, 0, 0, "R6"); route(2'b01, 0, 0, 1, 0, "R6"); route(2'b10, 1, 0, 0, 1, "R6");
    // R7 flip on C->A/B, both parity polarities
    route(2'b10, 1, 1, 1, 1, "R7");
    cycle(0, 0, 1, 0, 0, 9'h03C);
    route(2'b10, 1, 1, 1, 0, "R7");
    // R8 flip ignored for non-C sources
    route(2'b00, 1, 1, 1, 1, "R8"); route(2'b01, 1, 1, 1, 1, "R8");

    for (int i = 0; i < 300; i++) begin
      cycle($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
            9'($urandom), 9'($urandom), 9'($urandom));
      route(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R4_rand");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule